// File: doc/BRIEF.md
# Supply Sequencer with Two-Strike Hiccup Protection

This block decides when a primary-side switching regulator may switch and when its high-voltage charge source may feed the supply capacitor. It sees the supply voltage only as four digitized comparator flags (above the turn-on level, above the turn-off level, above the top-up level and above the restart level). It also sees a flag saying the rectified input is high enough for the charge source to work. The power switch gate is an input, and its falling edge marks the end of each switching cycle. On that edge the block samples an overcurrent comparator and a brownout comparator, which checks the sense-pin current during on-time.

A supply capacitor is charged from the input until it reaches the turn-on level, and switching then starts. While switching, a supply that sags below the top-up level is recharged during gate off-times until it is back at the turn-on level. A supply that sags below the turn-off level stops switching and charging resumes. Faults are filtered so that a single overcurrent cycle only raises a warning. A run of consecutive trips latches a fault, and so does a single brownout sample. A latched fault keeps both the switch and the charge source off. The latch clears on undervoltage, and charging restarts only once the supply has dropped below the restart level. This gives a slow hiccup with little stress on the power stage.

All inputs are plain level or edge signals; there is no streaming interface. The supply and input-voltage flags come from analog comparators and pass through a synchronizer of `SYNC_STAGES` flops. The gate, overcurrent and brownout inputs are taken to be in the clock domain already.

Top module: `supply_hiccup_seq`

## Requirements
- R1: While reset is held and on the first sample after it, `status_o` is 0 (off), and `sw_en_o` and `hv_en_o` are 0.
- R2: From off, the block moves to charging (status 1) once the restart flag is low. While charging, `sw_en_o` is 0 and `hv_en_o` equals the synchronized input-voltage flag.
- R3: From charging, the block moves to running (status 2, `sw_en_o` = 1) once the turn-on flag is high.
- R4: While running or warning, a low turn-off flag returns the block to charging (status 1, `sw_en_o` = 0). Undervoltage takes priority over any trip sampled in the same cycle.
- R5: While running, a low top-up flag arms a recharge request. The request drives `hv_en_o` high whenever `gate_i` is low and the input flag is high. It is cleared only when the turn-on flag is high again, so restoring the top-up flag alone keeps it armed.
- R6: `hv_en_o` is never high while the synchronized input-voltage flag is low, in any state.
- R7: An overcurrent sample on a gate falling edge while running gives the warning state (status 3). A following sample without overcurrent returns to running (status 2).
- R8: `STRIKES` consecutive overcurrent samples (default 2) latch the fault state (status 4). In that state `sw_en_o` = 0 and `hv_en_o` = 0.
- R9: The fault state is left only when the turn-off flag is low, and the block then goes to off (status 0, `hv_en_o` = 0). Off lasts until the restart flag is low.
- R10: A brownout sample on a gate falling edge while running or warning latches the fault state directly.
- R11: Overcurrent and brownout levels have no effect unless `gate_i` falls. A gate held high with both flags set leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vcc_on_i | input | 1 | Supply at or above the turn-on level |
| vcc_keep_i | input | 1 | Supply at or above the turn-off level |
| vcc_topup_i | input | 1 | Supply at or above the top-up level |
| vcc_restart_i | input | 1 | Supply at or above the restart level |
| line_ok_i | input | 1 | Rectified input above the charge-source start voltage |
| gate_i | input | 1 | Power switch gate; falling edge ends a cycle |
| ocp_i | input | 1 | Second-level overcurrent comparator |
| brownout_i | input | 1 | Sense-pin current too low during on-time |
| sw_en_o | output | 1 | Switching enable |
| hv_en_o | output | 1 | High-voltage charge source enable |
| status_o | output | 3 | 0 off, 1 charging, 2 running, 3 warning, 4 fault |

## Verification
A change on a supply or input-voltage flag reaches the state register after `SYNC_STAGES` synchronizer edges plus one state edge, which is three rising edges with the defaults. The bench therefore waits four full cycles after each level change before it samples. A gate pulse is driven high for one cycle and then low, with the overcurrent and brownout levels set in the low phase. The status changes on the rising edge that sees the fall, and the bench samples it on the next falling clock edge. `hv_en_o` follows `gate_i` without a register while a recharge request is armed, so those checks sample one time unit after the gate changes. All sixteen four-cycle overcurrent patterns are swept against a strike count tracked arithmetically in the bench.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    F_OFF    = 2'd0,
    F_CHARGE = 2'd1,
    F_RUN    = 2'd2,
    F_FAULT  = 2'd3
  } fsm_state_e;

  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_CHARGE = 3'd1,
    S_RUN    = 3'd2,
    S_WARN   = 3'd3,
    S_FAULT  = 3'd4
  } status_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain[0] <= d_i;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q_o = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sup_strike.sv
module sup_strike #(
  parameter int STRIKES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sample_i,
  input  logic ocp_i,
  output logic warn_o,
  output logic trip_o
);

  localparam int CW = (STRIKES < 2) ? 1 : $clog2(STRIKES);
  localparam logic [CW-1:0] LAST = CW'(STRIKES - 1);

  logic [CW-1:0] cnt;

  assign trip_o = sample_i & ocp_i & (cnt == LAST);
  assign warn_o = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear_i) begin
      cnt <= '0;
    end else if (sample_i) begin
      if (!ocp_i || trip_o) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end

  // R8: the run of trips never counts past the latching strike
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R7: a clean cycle sample drops the warning
  a_r7_clean_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !ocp_i) |=> (cnt == '0));

endmodule

// File: rtl/sup_recharge.sv
module sup_recharge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic topup_i,
  input  logic on_i,
  output logic need_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_o <= 1'b0;
    end else if (!en_i || on_i) begin
      need_o <= 1'b0;
    end else if (!topup_i) begin
      need_o <= 1'b1;
    end
  end

  // R5: a request is only armed after the supply was seen below the top-up level
  a_r5_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(need_o) |-> $past(!topup_i));

  // R5: reaching the turn-on level always releases the request
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    on_i |=> !need_o);

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_i,
  input  logic       keep_i,
  input  logic       restart_i,
  input  logic       trip_i,
  input  logic       brown_evt_i,
  output fsm_state_e state_o
);

  fsm_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      F_OFF:    if (!restart_i) nxt = F_CHARGE;
      F_CHARGE: if (on_i)       nxt = F_RUN;
      F_RUN: begin
        if (!keep_i)                    nxt = F_CHARGE;
        else if (trip_i || brown_evt_i) nxt = F_FAULT;
      end
      F_FAULT:  if (!keep_i)    nxt = F_OFF;
      default:  nxt = F_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= F_OFF;
    else        state_o <= nxt;
  end

  // R2: off is only ever left towards charging
  a_r2_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == F_OFF && state_o != F_OFF) |-> (state_o == F_CHARGE));

  // R3: switching is only entered from charging
  a_r3_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == F_RUN && $past(state_o) != F_RUN) |-> ($past(state_o) == F_CHARGE));

  // R9: the fault latch only clears into off
  a_r9_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == F_FAULT && state_o != F_FAULT) |-> (state_o == F_OFF));

  // R10: a brownout while switching with a healthy supply latches the fault
  a_r10_brown_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == F_RUN && keep_i && brown_evt_i) |=> (state_o == F_FAULT));

  // R4: undervoltage while switching wins over any trip
  a_r4_uvlo_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == F_RUN && !keep_i) |=> (state_o == F_CHARGE));

endmodule

// File: rtl/supply_hiccup_seq.sv
module supply_hiccup_seq
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRIKES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_keep_i,
  input  logic       vcc_topup_i,
  input  logic       vcc_restart_i,
  input  logic       line_ok_i,
  input  logic       gate_i,
  input  logic       ocp_i,
  input  logic       brownout_i,
  output logic       sw_en_o,
  output logic       hv_en_o,
  output logic [2:0] status_o
);

  localparam int NFLAG = 5;

  logic [NFLAG-1:0] flags_raw, flags_s;
  logic on_s, keep_s, topup_s, restart_s, line_s;
  logic gate_q, sample;
  logic warn, trip, need;
  logic running;
  fsm_state_e state;

  assign flags_raw = {line_ok_i, vcc_restart_i, vcc_topup_i, vcc_keep_i, vcc_on_i};

  sup_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  assign {line_s, restart_s, topup_s, keep_s, on_s} = flags_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign sample  = gate_q & ~gate_i;
  assign running = (state == F_RUN);

  sup_strike #(.STRIKES(STRIKES)) i_strike (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (~running | ~keep_s),
    .sample_i (sample),
    .ocp_i    (ocp_i),
    .warn_o   (warn),
    .trip_o   (trip)
  );

  sup_recharge i_recharge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (running),
    .topup_i (topup_s),
    .on_i    (on_s),
    .need_o  (need)
  );

  sup_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_i        (on_s),
    .keep_i      (keep_s),
    .restart_i   (restart_s),
    .trip_i      (trip),
    .brown_evt_i (sample & brownout_i),
    .state_o     (state)
  );

  assign sw_en_o = running;
  assign hv_en_o = line_s & ((state == F_CHARGE) | (running & need & ~gate_i));

  always_comb begin
    unique case (state)
      F_OFF:    status_o = S_OFF;
      F_CHARGE: status_o = S_CHARGE;
      F_RUN:    status_o = warn ? S_WARN : S_RUN;
      F_FAULT:  status_o = S_FAULT;
      default:  status_o = S_OFF;
    endcase
  end

  // R6: the charge source never runs without enough input voltage
  a_r6_line_gate: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en_o |-> line_s);

  // R8: a latched fault keeps the power stage and the charge source quiet
  a_r8_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == S_FAULT && status_o == S_FAULT) |-> (!sw_en_o && !hv_en_o));

  // R11: without a gate falling edge the warning level cannot move
  a_r11_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && keep_s && !sample) |=> ($stable(warn) || !running));

endmodule

// File: tb/test_supply_hiccup_seq.sv
module test_supply_hiccup_seq;

  localparam int PERIOD = 10;
  localparam int SYNC   = 2;
  localparam int SETTLE = SYNC + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic on_f, keep_f, topup_f, restart_f, line_f;
  logic gate, ocp, brown;
  logic sw_en, hv_en;
  logic [2:0] status;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  supply_hiccup_seq #(.SYNC_STAGES(SYNC), .STRIKES(2)) i_supply_hiccup_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_on_i      (on_f),
    .vcc_keep_i    (keep_f),
    .vcc_topup_i   (topup_f),
    .vcc_restart_i (restart_f),
    .line_ok_i     (line_f),
    .gate_i        (gate),
    .ocp_i         (ocp),
    .brownout_i    (brown),
    .sw_en_o       (sw_en),
    .hv_en_o       (hv_en),
    .status_o      (status)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse(input logic oc, input logic bo);
    gate = 1'b1;
    @(negedge clk);
    gate = 1'b0; ocp = oc; brown = bo;
    @(negedge clk);
    ocp = 1'b0; brown = 1'b0;
  endtask

  task automatic power_to_run();
    rst_n = 1'b0;
    {on_f, keep_f, topup_f, restart_f} = 4'b0;
    line_f = 1'b1; gate = 1'b0; ocp = 1'b0; brown = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    keep_f = 1'b1; topup_f = 1'b1; restart_f = 1'b1;
    settle();
    on_f = 1'b1;
    settle();
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {on_f, keep_f, topup_f, restart_f} = 4'b0;
    line_f = 1'b1; gate = 1'b0; ocp = 1'b0; brown = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 status in reset", status, 0);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 hv_en in reset", hv_en, 0);
    rst_n = 1'b1;
    settle();
    // R2: restart flag low at power-up, so charging with the source on
    chk("R2 charging", status, 1);
    chk("R2 sw off", sw_en, 0);
    chk("R2 hv follows line", hv_en, 1);
    line_f = 1'b0; settle();
    chk("R6 hv off without line", hv_en, 0);
    line_f = 1'b1; settle();
    keep_f = 1'b1; topup_f = 1'b1; restart_f = 1'b1; settle();
    chk("R3 still charging below on level", status, 1);
    on_f = 1'b1; settle();
    chk("R3 running", status, 2);
    chk("R3 sw on", sw_en, 1);
    chk("R5 no recharge when healthy", hv_en, 0);

    // R5: sag below the top-up level arms recharge on off-times
    on_f = 1'b0; settle();
    chk("R5 no request above top-up", hv_en, 0);
    topup_f = 1'b0; settle();
    chk("R5 still running", status, 2);
    for (int g = 0; g < 2; g++) begin
      for (int l = 0; l < 2; l++) begin
        line_f = l[0]; settle();
        gate = g[0]; #1;
        chk("R5 hv during sag (R6 line)", hv_en, (g == 0 && l == 1) ? 1 : 0);
        @(negedge clk);
        gate = 1'b0; ocp = 1'b0;
      end
    end
    line_f = 1'b1;
    topup_f = 1'b1; settle();
    #1 chk("R5 request held past top-up", hv_en, 1);
    on_f = 1'b1; settle();
    #1 chk("R5 request released at on level", hv_en, 0);

    // R11: levels without a gate fall do nothing
    gate = 1'b1; ocp = 1'b1; brown = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 gate held high, no effect", status, 2);
    ocp = 1'b0; brown = 1'b0; gate = 1'b0;
    @(negedge clk);
    chk("R11 clean fall keeps running", status, 2);

    // R4: undervoltage while running
    keep_f = 1'b0; on_f = 1'b0; settle();
    chk("R4 uvlo to charging", status, 1);
    chk("R4 sw off", sw_en, 0);

    // R7/R8: sweep every 4-cycle overcurrent pattern
    for (int p = 0; p < 16; p++) begin
      int cnt;
      bit flt;
      power_to_run();
      cnt = 0; flt = 0;
      for (int k = 0; k < 4; k++) begin
        logic oc;
        int exp;
        oc = p[k];
        pulse(oc, 1'b0);
        if (!flt) begin
          if (oc) begin
            if (cnt == 1) flt = 1; else cnt = 1;
          end else cnt = 0;
        end
        exp = flt ? 4 : (cnt == 1 ? 3 : 2);
        chk("R7 R8 strike sweep status", status, exp);
      end
      chk("R8 sw_en vs fault", sw_en, flt ? 0 : 1);
    end

    // R8/R9: latched fault and hiccup restart
    power_to_run();
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R8 second strike faults", status, 4);
    on_f = 1'b0; topup_f = 1'b0; settle();
    #1 chk("R8 no charging in fault", hv_en, 0);
    chk("R9 fault held above turn-off", status, 4);
    keep_f = 1'b0; settle();
    chk("R9 uvlo clears to off", status, 0);
    chk("R9 no charging in off", hv_en, 0);
    restart_f = 1'b0; settle();
    chk("R9 restart to charging", status, 1);
    chk("R9 charging resumed", hv_en, 1);

    // R10: brownout latches at once, also from warning
    power_to_run();
    pulse(1'b0, 1'b1);
    chk("R10 brownout from running", status, 4);
    power_to_run();
    pulse(1'b1, 1'b0);
    chk("R7 warn before brownout", status, 3);
    pulse(1'b0, 1'b1);
    chk("R10 brownout from warning", status, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule